// File: doc/BRIEF.md
# Hotplug General Purpose Event Controller

This block records slot insertion and removal events for a hot-pluggable bus and reports them to the host. It has a small byte-wide event register window holding a 16-bit event status register and a 16-bit event enable register, and a 32-bit word window holding an insertion mask, a removal mask and an eject command register.

A hotplug event arrives with a 5-bit slot number and a direction flag. Each event wipes both slot masks and then marks only the new slot in the mask that matches the direction. It also sets status bit 1. When enable bit 1 is set, the block raises a one-cycle interrupt pulse. Host software clears status one byte lane at a time with write-one-to-clear semantics. Writing a non-zero value to the eject register issues a one-cycle eject strobe that carries the index of the lowest set bit of the value. The actual device teardown is handled downstream.

Top module: `hp_gpe_ctrl`

## Requirements
- R1: After reset the status and enable registers read 0 at every byte offset, both slot masks read 0, and `irq_o` and `eject_o` are low.
- R2: A byte write to status offset 0 (bits 7:0) or offset 1 (bits 15:8) clears each bit of that lane where the written byte has a one. All other status bits keep their value.
- R3: A byte write to enable offset 2 (bits 7:0) or offset 3 (bits 15:8) replaces that lane with the written byte and leaves the other lane unchanged.
- R4: A byte read returns the addressed lane: offset 0 is the status low byte, 1 the status high byte, 2 the enable low byte, 3 the enable high byte. Offsets 4 to 7 read 0.
- R5: A hotplug event clears both slot masks, sets status bit 1, and sets bit `slot` of the insertion mask when `hp_insert_i`=1 or of the removal mask when `hp_insert_i`=0. The result is visible from the cycle after the event.
- R6: When enable bit 1 is set in the event cycle, `irq_o` is high for exactly the one cycle after the event. When enable bit 1 is clear, `irq_o` stays low.
- R7: The insertion mask is read and written at word address 0 and the removal mask at word address 4. Word address 8 (eject) and word address 12 read 0.
- R8: A write of a non-zero value to word address 8 raises `eject_o` for exactly the next cycle, with `eject_slot_o` equal to the bit position of the lowest set bit of the written value.
- R9: A write of zero to word address 8 produces no eject strobe.
- R10: In the cycle of a hotplug event, the event overrides a simultaneous host write to a slot mask and a simultaneous clear of status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bwr_en_i | input | 1 | Byte window write strobe |
| b_wr_off_i | input | 3 | Byte window write offset |
| b_wr_data_i | input | 8 | Byte window write data |
| b_rd_off_i | input | 3 | Byte window read offset |
| b_rd_data_o | output | 8 | Byte window read data (combinational) |
| wwr_en_i | input | 1 | Word window write strobe |
| w_wr_addr_i | input | 4 | Word window write byte address |
| w_wr_data_i | input | 32 | Word window write data |
| w_rd_addr_i | input | 4 | Word window read byte address |
| w_rd_data_o | output | 32 | Word window read data (combinational) |
| hp_valid_i | input | 1 | Hotplug event valid |
| hp_insert_i | input | 1 | 1 = insertion, 0 = removal |
| hp_slot_i | input | 5 | Slot number of the event |
| irq_o | output | 1 | Interrupt pulse |
| eject_o | output | 1 | Eject strobe |
| eject_slot_o | output | 5 | Slot index carried with the eject strobe |

## Verification
The bench checks lane isolation in both directions. If a status clear leaks into the other lane, or an enable write spills across lanes, a neighbouring byte that should hold its value reads back changed. Reads at offsets 4 to 7 are checked while the enable register holds non-zero data, so an offset decoder that ignores bit 2 returns the aliased enable byte. The eject cases use values with several set bits and the extreme positions 0 and 31, so a design that picks the highest set bit, or one that strobes on a zero write, reports the wrong slot or a spurious pulse. A final cycle combines an event with a mask write and a status clear. This shows whether the event wins, and whether the interrupt respects a cleared enable bit.

// File: rtl/hp_gpe_pkg.sv
package hp_gpe_pkg;
  localparam int unsigned LANE_W = 8;

  // word window indices, taken from byte address bits [3:2]
  typedef enum logic [1:0] {
    WIDX_INS  = 2'd0,
    WIDX_REM  = 2'd1,
    WIDX_EJ   = 2'd2,
    WIDX_NONE = 2'd3
  } widx_e;
endpackage

// File: rtl/gpe_byte_regs.sv
module gpe_byte_regs #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned OFF_W = 3,
  parameter int unsigned EVT_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_data_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_data_o,
  input  logic             evt_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o
);
  localparam int unsigned NLANE = REG_W / 8;

  logic [REG_W-1:0] sts_q, en_q;
  logic [REG_W-1:0] sts_clr, en_d;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam logic [OFF_W-1:0] STS_OFF = OFF_W'(l);
    localparam logic [OFF_W-1:0] EN_OFF  = OFF_W'(l + NLANE);
    always_comb begin
      sts_clr[l*8 +: 8] = (wr_en_i && wr_off_i == STS_OFF) ? wr_data_i : 8'h00;
      en_d[l*8 +: 8]    = (wr_en_i && wr_off_i == EN_OFF)  ? wr_data_i : en_q[l*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      // event set after clear: a simultaneous event wins
      sts_q <= (sts_q & ~sts_clr) | (REG_W'(evt_i) << EVT_BIT);
      en_q  <= en_d;
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int l = 0; l < NLANE; l++) begin
      if (rd_off_i == OFF_W'(l))         rd_data_o = sts_q[l*8 +: 8];
      if (rd_off_i == OFF_W'(l + NLANE)) rd_data_o = en_q[l*8 +: 8];
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned MASK_W = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ins_i,
  input  logic              wr_rem_i,
  input  logic [MASK_W-1:0] wr_data_i,
  input  logic              evt_i,
  input  logic              evt_insert_i,
  input  logic [SLOT_W-1:0] evt_slot_i,
  output logic [MASK_W-1:0] ins_o,
  output logic [MASK_W-1:0] rem_o
);
  logic [MASK_W-1:0] ins_q, rem_q, onehot;

  assign onehot = MASK_W'(1) << evt_slot_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (evt_i) begin
      ins_q <= evt_insert_i ? onehot : '0;
      rem_q <= evt_insert_i ? '0 : onehot;
    end else begin
      if (wr_ins_i) ins_q <= wr_data_i;
      if (wr_rem_i) rem_q <= wr_data_i;
    end
  end

  assign ins_o = ins_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/eject_dec.sv
module eject_dec #(
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned MASK_W = 1 << SLOT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MASK_W-1:0] data_i,
  output logic              strobe_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] lsb_idx;
  logic              strobe_q;
  logic [SLOT_W-1:0] slot_q;

  // scan down so the lowest set bit is the last assignment
  always_comb begin
    lsb_idx = '0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (data_i[i]) lsb_idx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      slot_q   <= '0;
    end else begin
      strobe_q <= wr_i && (data_i != '0);
      if (wr_i && (data_i != '0)) slot_q <= lsb_idx;
    end
  end

  assign strobe_o = strobe_q;
  assign slot_o   = slot_q;
endmodule

// File: rtl/hp_gpe_ctrl.sv
module hp_gpe_ctrl #(
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned GPE_W   = 16,
  parameter int unsigned OFF_W   = 3,
  parameter int unsigned WADDR_W = 4,
  localparam int unsigned MASK_W = 1 << SLOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bwr_en_i,
  input  logic [OFF_W-1:0]   b_wr_off_i,
  input  logic [7:0]         b_wr_data_i,
  input  logic [OFF_W-1:0]   b_rd_off_i,
  output logic [7:0]         b_rd_data_o,
  input  logic               wwr_en_i,
  input  logic [WADDR_W-1:0] w_wr_addr_i,
  input  logic [MASK_W-1:0]  w_wr_data_i,
  input  logic [WADDR_W-1:0] w_rd_addr_i,
  output logic [MASK_W-1:0]  w_rd_data_o,
  input  logic               hp_valid_i,
  input  logic               hp_insert_i,
  input  logic [SLOT_W-1:0]  hp_slot_i,
  output logic               irq_o,
  output logic               eject_o,
  output logic [SLOT_W-1:0]  eject_slot_o
);
  import hp_gpe_pkg::*;

  localparam int unsigned EVT_BIT = 1;

  logic [GPE_W-1:0]  sts_q, en_q;
  logic [MASK_W-1:0] ins_q, rem_q;
  widx_e             wr_idx, rd_idx;
  logic              irq_q;

  assign wr_idx = widx_e'(w_wr_addr_i[3:2]);
  assign rd_idx = widx_e'(w_rd_addr_i[3:2]);

  gpe_byte_regs #(.REG_W(GPE_W), .OFF_W(OFF_W), .EVT_BIT(EVT_BIT)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (bwr_en_i),
    .wr_off_i  (b_wr_off_i),
    .wr_data_i (b_wr_data_i),
    .rd_off_i  (b_rd_off_i),
    .rd_data_o (b_rd_data_o),
    .evt_i     (hp_valid_i),
    .sts_o     (sts_q),
    .en_o      (en_q)
  );

  slot_tracker #(.SLOT_W(SLOT_W)) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ins_i     (wwr_en_i && wr_idx == WIDX_INS),
    .wr_rem_i     (wwr_en_i && wr_idx == WIDX_REM),
    .wr_data_i    (w_wr_data_i),
    .evt_i        (hp_valid_i),
    .evt_insert_i (hp_insert_i),
    .evt_slot_i   (hp_slot_i),
    .ins_o        (ins_q),
    .rem_o        (rem_q)
  );

  eject_dec #(.SLOT_W(SLOT_W)) u_eject (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wwr_en_i && wr_idx == WIDX_EJ),
    .data_i   (w_wr_data_i),
    .strobe_o (eject_o),
    .slot_o   (eject_slot_o)
  );

  always_comb begin
    unique case (rd_idx)
      WIDX_INS: w_rd_data_o = ins_q;
      WIDX_REM: w_rd_data_o = rem_q;
      default:  w_rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hp_valid_i && en_q[EVT_BIT];
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hp_gpe_ctrl_chk.sv
module hp_gpe_ctrl_chk #(
  parameter int unsigned SLOT_W  = 5,
  parameter int unsigned GPE_W   = 16,
  parameter int unsigned OFF_W   = 3,
  parameter int unsigned WADDR_W = 4,
  localparam int unsigned MASK_W = 1 << SLOT_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               hp_valid_i,
  input logic               irq_o,
  input logic [GPE_W-1:0]   en_q,
  input logic [GPE_W-1:0]   sts_q,
  input logic [MASK_W-1:0]  ins_q,
  input logic [MASK_W-1:0]  rem_q,
  input logic               eject_o,
  input logic [SLOT_W-1:0]  eject_slot_o,
  input logic               wwr_en_i,
  input logic [WADDR_W-1:0] w_wr_addr_i,
  input logic [MASK_W-1:0]  w_wr_data_i,
  input logic               bwr_en_i,
  input logic [OFF_W-1:0]   b_wr_off_i
);
  p_irq_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(hp_valid_i && en_q[1]));

  p_irq_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_valid_i && !en_q[1]) |=> !irq_o);

  p_evt_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid_i |=> sts_q[1]);

  p_evt_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_valid_i |=> ($countones({ins_q, rem_q}) == 1));

  p_eject_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_o |-> $past(wwr_en_i && w_wr_addr_i[3:2] == 2'd2 && w_wr_data_i != '0));

  p_eject_lsb_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_o |-> ((($past(w_wr_data_i) >> eject_slot_o) & MASK_W'(1)) == MASK_W'(1)) &&
                (($past(w_wr_data_i) & ((MASK_W'(1) << eject_slot_o) - MASK_W'(1))) == '0));

  p_sts_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bwr_en_i && b_wr_off_i == OFF_W'(1) && !hp_valid_i) |=> (sts_q[7:0] == $past(sts_q[7:0])));
endmodule

bind hp_gpe_ctrl hp_gpe_ctrl_chk #(
  .SLOT_W(SLOT_W), .GPE_W(GPE_W), .OFF_W(OFF_W), .WADDR_W(WADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hp_valid_i   (hp_valid_i),
  .irq_o        (irq_o),
  .en_q         (en_q),
  .sts_q        (sts_q),
  .ins_q        (ins_q),
  .rem_q        (rem_q),
  .eject_o      (eject_o),
  .eject_slot_o (eject_slot_o),
  .wwr_en_i     (wwr_en_i),
  .w_wr_addr_i  (w_wr_addr_i),
  .w_wr_data_i  (w_wr_data_i),
  .bwr_en_i     (bwr_en_i),
  .b_wr_off_i   (b_wr_off_i)
);

// File: tb/hp_gpe_ctrl_tb_top.sv
module hp_gpe_ctrl_tb_top;
  localparam int K_BYTE = 0, K_WORD = 1, K_IRQ = 2, K_EJ = 3, K_SLOT = 4;

  typedef struct {
    int          kind;
    int          due;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bwr_en = 1'b0;
  logic [2:0]  b_wr_off = '0;
  logic [7:0]  b_wr_data = '0;
  logic [2:0]  b_rd_off = '0;
  logic [7:0]  b_rd_data;
  logic        wwr_en = 1'b0;
  logic [3:0]  w_wr_addr = '0;
  logic [31:0] w_wr_data = '0;
  logic [3:0]  w_rd_addr = '0;
  logic [31:0] w_rd_data;
  logic        hp_valid = 1'b0;
  logic        hp_insert = 1'b0;
  logic [4:0]  hp_slot = '0;
  logic        irq, eject;
  logic [4:0]  eject_slot;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  hp_gpe_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bwr_en_i(bwr_en), .b_wr_off_i(b_wr_off), .b_wr_data_i(b_wr_data),
    .b_rd_off_i(b_rd_off), .b_rd_data_o(b_rd_data),
    .wwr_en_i(wwr_en), .w_wr_addr_i(w_wr_addr), .w_wr_data_i(w_wr_data),
    .w_rd_addr_i(w_rd_addr), .w_rd_data_o(w_rd_data),
    .hp_valid_i(hp_valid), .hp_insert_i(hp_insert), .hp_slot_i(hp_slot),
    .irq_o(irq), .eject_o(eject), .eject_slot_o(eject_slot)
  );

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        logic [31:0] act;
        case (sb_q[i].kind)
          K_BYTE:  act = {24'h0, b_rd_data};
          K_WORD:  act = w_rd_data;
          K_IRQ:   act = {31'h0, irq};
          K_EJ:    act = {31'h0, eject};
          default: act = {27'h0, eject_slot};
        endcase
        n_chk++;
        if (act !== sb_q[i].exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual %h expected %h", sb_q[i].tag, sb_q[i].kind, act, sb_q[i].exp);
        end
        sb_q.delete(i);
      end
    end
  end

  task automatic push(int kind, int due, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.due = due; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    bwr_en = 1'b0; wwr_en = 1'b0; hp_valid = 1'b0;
  endtask

  task automatic bwr(logic [2:0] off, logic [7:0] d);
    bwr_en = 1'b1; b_wr_off = off; b_wr_data = d; tick();
  endtask

  task automatic wwr(logic [3:0] a, logic [31:0] d);
    wwr_en = 1'b1; w_wr_addr = a; w_wr_data = d; tick();
  endtask

  task automatic chk_byte(logic [2:0] off, logic [7:0] e, string tag);
    b_rd_off = off; push(K_BYTE, cyc, {24'h0, e}, tag); tick();
  endtask

  task automatic chk_word(logic [3:0] a, logic [31:0] e, string tag);
    w_rd_addr = a; push(K_WORD, cyc, e, tag); tick();
  endtask

  task automatic ev(logic ins, logic [4:0] slot, logic exp_irq, string tag);
    hp_valid = 1'b1; hp_insert = ins; hp_slot = slot; tick();
    push(K_IRQ, cyc, {31'h0, exp_irq}, tag);
    push(K_IRQ, cyc + 1, 32'h0, tag);
    tick();
  endtask

  task automatic ej(logic [31:0] d, logic exp_stb, logic [4:0] exp_slot, string tag);
    wwr(4'd8, d);
    push(K_EJ, cyc, {31'h0, exp_stb}, tag);
    if (exp_stb) push(K_SLOT, cyc, {27'h0, exp_slot}, tag);
    push(K_EJ, cyc + 1, 32'h0, tag);
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    push(K_IRQ, cyc, 0, "R1 irq");
    push(K_EJ, cyc, 0, "R1 eject");
    for (int o = 0; o < 4; o++) chk_byte(3'(o), 8'h00, "R1 byte");
    chk_word(4'd0, 32'h0, "R1 ins");
    chk_word(4'd4, 32'h0, "R1 rem");
    // R3 enable lanes
    bwr(3'd2, 8'h02);
    bwr(3'd3, 8'hA5);
    chk_byte(3'd2, 8'h02, "R3 en lo");
    chk_byte(3'd3, 8'hA5, "R3 en hi");
    bwr(3'd3, 8'h5A);
    chk_byte(3'd2, 8'h02, "R3 lo kept");
    chk_byte(3'd3, 8'h5A, "R3 hi new");
    // R5 / R6 events with interrupt enabled
    ev(1'b1, 5'd7, 1'b1, "R6 irq insert");
    chk_byte(3'd0, 8'h02, "R5 status");
    chk_word(4'd0, 32'h0000_0080, "R5 ins slot7");
    chk_word(4'd4, 32'h0, "R5 rem clear");
    ev(1'b0, 5'd31, 1'b1, "R6 irq remove");
    chk_word(4'd0, 32'h0, "R5 ins clear");
    chk_word(4'd4, 32'h8000_0000, "R5 rem slot31");
    // R2 write-one-to-clear per lane
    bwr(3'd1, 8'hFF);
    chk_byte(3'd0, 8'h02, "R2 other lane kept");
    bwr(3'd0, 8'h01);
    chk_byte(3'd0, 8'h02, "R2 zero bits kept");
    bwr(3'd0, 8'h02);
    chk_byte(3'd0, 8'h00, "R2 cleared");
    chk_byte(3'd1, 8'h00, "R2 hi");
    // R4 out-of-window offsets while enable is non-zero
    for (int o = 4; o < 8; o++) chk_byte(3'(o), 8'h00, "R4 outside");
    chk_byte(3'd1, 8'h00, "R4 sts hi");
    // R6 masked interrupt
    bwr(3'd2, 8'h00);
    ev(1'b1, 5'd3, 1'b0, "R6 masked");
    chk_byte(3'd0, 8'h02, "R5 status masked");
    chk_byte(3'd3, 8'h5A, "R3 hi untouched");
    // R7 host access to masks
    wwr(4'd0, 32'hDEAD_BEEF);
    wwr(4'd4, 32'h1234_5678);
    chk_word(4'd0, 32'hDEAD_BEEF, "R7 ins");
    chk_word(4'd4, 32'h1234_5678, "R7 rem");
    chk_word(4'd8, 32'h0, "R7 eject reads 0");
    chk_word(4'd12, 32'h0, "R7 unused");
    // R8 / R9 eject
    ej(32'h0000_0028, 1'b1, 5'd3, "R8 lsb 3");
    ej(32'h8000_0000, 1'b1, 5'd31, "R8 lsb 31");
    ej(32'hFFFF_FFFF, 1'b1, 5'd0, "R8 lsb 0");
    ej(32'h0, 1'b0, 5'd0, "R9 zero");
    chk_word(4'd0, 32'hDEAD_BEEF, "R9 masks untouched");
    // R10 event beats simultaneous mask write and status clear
    bwr(3'd0, 8'h02);
    wwr_en = 1'b1; w_wr_addr = 4'd0; w_wr_data = 32'hFFFF_FFFF;
    bwr_en = 1'b1; b_wr_off = 3'd0; b_wr_data = 8'h02;
    hp_valid = 1'b1; hp_insert = 1'b1; hp_slot = 5'd2;
    tick();
    push(K_IRQ, cyc, 0, "R10 irq masked");
    chk_word(4'd0, 32'h0000_0004, "R10 ins");
    chk_word(4'd4, 32'h0, "R10 rem");
    chk_byte(3'd0, 8'h02, "R10 status");
    repeat (3) tick();
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule